// File: doc/BRIEF.md
# RTC interrupt and square-wave generator

This block turns three timekeeping events into one active-low interrupt request, and it drives a programmable square-wave pin. The events are a rising edge on a selected divider tap (periodic), the end-of-update strobe from the time counters (update-ended), and that same strobe arriving while the current time matches the alarm bytes (alarm). Each event sets its own pending flag whether or not it is enabled. The interrupt line goes low while any flag is pending and its enable is set.

Software reads a status byte with a read strobe. The first cycle of the strobe copies all flags and the summary bit into the status register and clears the flags, which releases the interrupt line. A 4-bit rate field picks the divider tap. That tap is both the periodic interrupt source and the square-wave source, and a rate of zero turns both off. Each alarm field holding a value with its two top bits set matches any time value. This gives an alarm that fires every second, every minute, every hour or once a day.

Two small state machines control the block.

The periodic edge tracker has three states, `PER_OFF`, `PER_LOW` and `PER_HIGH`:
- It enters `PER_OFF` whenever the rate is zero.
- From `PER_OFF`, or on any cycle where the rate differs from the previous cycle, it jumps straight to `PER_LOW` or `PER_HIGH` to match the current tap. This resync raises no event.
- The transition `PER_LOW`→`PER_HIGH` on a high tap is the periodic event.
- The transition `PER_HIGH`→`PER_LOW` happens on a low tap.

The read tracker has two states, `RD_IDLE` and `RD_HELD`:
- `RD_IDLE`→`RD_HELD` on a high strobe. That transition is the read that captures and clears.
- `RD_HELD`→`RD_IDLE` when the strobe falls.

Top module: `rtc_event_irq`

## Requirements
- R1: After reset `irq_n` is 1, `sqw` is 0 and `stat_q` is 0.
- R2: A cycle with `upd_end` high sets the update flag, even when `upd_en` is 0.
- R3: A cycle with `upd_end` high sets the alarm flag when all three fields (seconds, minutes, hours) match. A field matches if its alarm byte equals the time byte, or if the alarm byte has bits 7 and 6 both set.
- R4: The rate field r (1..15) selects divider bit r-1. A rising edge of that bit sets the periodic flag. A cycle where r changes, or the cycle that leaves r=0, raises no periodic event. With r=0 the periodic flag is never set.
- R5: On each clock edge `sqw` takes the selected tap if `sqw_en` is 1 and r is nonzero; otherwise it is 0.
- R6: `irq_n` is 0 exactly while a pending flag has its enable set (`per_en`, `alm_en`, `upd_en`).
- R7: On the first cycle of a high `rd_stat`, `stat_q` loads the status byte and all flags clear. The byte is laid out as bit7 = summary (the R6 condition), bit6 = periodic, bit5 = alarm, bit4 = update, and bits 3..0 = 0. Further high cycles of the same strobe do nothing.
- R8: An event in the same cycle as a read is not lost. The captured byte shows the old flags, and the new flag stays pending.
- R9: `stat_q` keeps its value between reads, including while a strobe is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_q | input | 15 | Divider chain value; bit k is the k-th tap |
| rate_sel | input | 4 | Rate field; 0 disables periodic and square wave |
| per_en | input | 1 | Periodic interrupt enable |
| alm_en | input | 1 | Alarm interrupt enable |
| upd_en | input | 1 | Update-ended interrupt enable |
| sqw_en | input | 1 | Square-wave output enable |
| upd_end | input | 1 | End-of-update strobe, one cycle |
| tm_sec | input | 8 | Current seconds |
| tm_min | input | 8 | Current minutes |
| tm_hr | input | 8 | Current hours |
| al_sec | input | 8 | Alarm seconds |
| al_min | input | 8 | Alarm minutes |
| al_hr | input | 8 | Alarm hours |
| rd_stat | input | 1 | Status read strobe |
| stat_q | output | 8 | Captured status byte |
| irq_n | output | 1 | Interrupt request, active low |
| sqw | output | 1 | Square-wave output |

## Verification
The flags, the captured status byte and `sqw` are registered, so each one is due one clock edge after the inputs that cause it. `irq_n` follows the flag registers combinationally and settles in that same cycle. The bench drives inputs on the falling edge, advances one rising edge and compares all three outputs on the next falling edge against a cycle model built from the requirements. Directed sequences add fixed expected bytes for the resync, coincident-read and held-strobe cases.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    typedef enum logic [1:0] {
        PER_OFF  = 2'd0,
        PER_LOW  = 2'd1,
        PER_HIGH = 2'd2
    } per_state_e;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_HELD = 1'b1
    } rd_state_e;

    localparam int NFLAG   = 3;
    localparam int FLAG_UF = 0;
    localparam int FLAG_AF = 1;
    localparam int FLAG_PF = 2;

endpackage

// File: rtl/rtc_rate_tap.sv
module rtc_rate_tap
    import rtc_irq_pkg::*;
#(
    parameter int DIV_W  = 15,
    parameter int RATE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_q,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              sqw_en,
    output logic              per_evt,
    output logic              sqw_q
);
    localparam int NSEL = 1 << RATE_W;

    logic [NSEL-1:0]   tap_vec;
    logic              tap;
    logic              rate_on;
    logic [RATE_W-1:0] rate_q;
    per_state_e        state_q, state_d;

    // Tap table: code 0 and codes past the divider width read as 0
    for (genvar k = 0; k < NSEL; k++) begin : g_tap
        if (k == 0 || k > DIV_W) begin : g_zero
            assign tap_vec[k] = 1'b0;
        end else begin : g_bit
            assign tap_vec[k] = div_q[k-1];
        end
    end

    assign tap     = tap_vec[rate_sel];
    assign rate_on = (rate_sel != '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PER_OFF;
            rate_q  <= '0;
        end else begin
            state_q <= state_d;
            rate_q  <= rate_sel;
        end
    end

    // Next state and event
    always_comb begin
        state_d = state_q;
        per_evt = 1'b0;
        if (!rate_on) begin
            state_d = PER_OFF;
        end else if (state_q == PER_OFF || rate_sel != rate_q) begin
            state_d = tap ? PER_HIGH : PER_LOW;
        end else begin
            unique case (state_q)
                PER_LOW: begin
                    if (tap) begin
                        state_d = PER_HIGH;
                        per_evt = 1'b1;
                    end
                end
                PER_HIGH: begin
                    if (!tap) state_d = PER_LOW;
                end
                default: state_d = PER_OFF;
            endcase
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sqw_q <= 1'b0;
        else        sqw_q <= sqw_en && rate_on && tap;
    end

    // R4: an edge event cannot repeat on the next cycle
    a_r4_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        per_evt |=> !per_evt);

    // R5: output low after a disabled cycle
    a_r5_sqw_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!rate_on || !sqw_en) |=> !sqw_q);

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
    parameter int NF = 3,
    parameter int FW = 8
) (
    input  logic [NF*FW-1:0] tm_vec,
    input  logic [NF*FW-1:0] al_vec,
    output logic             match
);
    logic [NF-1:0] hit;

    for (genvar i = 0; i < NF; i++) begin : g_field
        logic [FW-1:0] a_f, t_f;
        assign a_f    = al_vec[i*FW +: FW];
        assign t_f    = tm_vec[i*FW +: FW];
        assign hit[i] = (a_f[FW-1:FW-2] == 2'b11) || (a_f == t_f);
    end

    assign match = &hit;

endmodule

// File: rtl/rtc_flag_ctrl.sv
module rtc_flag_ctrl
    import rtc_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_vec,
    input  logic [NFLAG-1:0] en_vec,
    input  logic             rd_stat,
    output logic [7:0]       stat_q,
    output logic             irq_n
);
    rd_state_e        rd_q, rd_d;
    logic             rd_fire;
    logic [NFLAG-1:0] flag_q, flag_d;
    logic             live;

    // Read tracker state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= RD_IDLE;
        else        rd_q <= rd_d;
    end

    always_comb begin
        rd_d    = rd_q;
        rd_fire = 1'b0;
        unique case (rd_q)
            RD_IDLE: begin
                if (rd_stat) begin
                    rd_d    = RD_HELD;
                    rd_fire = 1'b1;
                end
            end
            RD_HELD: begin
                if (!rd_stat) rd_d = RD_IDLE;
            end
            default: rd_d = RD_IDLE;
        endcase
    end

    assign live   = |(flag_q & en_vec);
    assign flag_d = (rd_fire ? '0 : flag_q) | set_vec;

    // Flags and status byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
            stat_q <= '0;
        end else begin
            flag_q <= flag_d;
            if (rd_fire)
                stat_q <= {live, flag_q[FLAG_PF], flag_q[FLAG_AF], flag_q[FLAG_UF], 4'b0000};
        end
    end

    assign irq_n = !live;

    // R2: update strobe leaves the flag pending
    a_r2_uf_pending: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[FLAG_UF] |=> flag_q[FLAG_UF]);

    // R7: a quiet read leaves no flag behind
    a_r7_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && set_vec == '0) |=> (flag_q == '0));

    // R7: one strobe gives one capture
    a_r7_one_capture: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |=> !rd_fire);

    // R9: no capture, no change
    a_r9_stat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_fire |=> $stable(stat_q));

endmodule

// File: rtl/rtc_event_irq.sv
module rtc_event_irq
    import rtc_irq_pkg::*;
#(
    parameter int DIV_W  = 15,
    parameter int RATE_W = 4,
    parameter int FW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_q,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              per_en,
    input  logic              alm_en,
    input  logic              upd_en,
    input  logic              sqw_en,
    input  logic              upd_end,
    input  logic [FW-1:0]     tm_sec,
    input  logic [FW-1:0]     tm_min,
    input  logic [FW-1:0]     tm_hr,
    input  logic [FW-1:0]     al_sec,
    input  logic [FW-1:0]     al_min,
    input  logic [FW-1:0]     al_hr,
    input  logic              rd_stat,
    output logic [7:0]        stat_q,
    output logic              irq_n,
    output logic              sqw
);
    localparam int NF = 3;

    logic             per_evt;
    logic             al_match;
    logic [NFLAG-1:0] set_vec;
    logic [NFLAG-1:0] en_vec;

    rtc_rate_tap #(.DIV_W(DIV_W), .RATE_W(RATE_W)) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_q    (div_q),
        .rate_sel (rate_sel),
        .sqw_en   (sqw_en),
        .per_evt  (per_evt),
        .sqw_q    (sqw)
    );

    rtc_alarm_cmp #(.NF(NF), .FW(FW)) u_alarm (
        .tm_vec (({tm_hr, tm_min, tm_sec})),
        .al_vec (({al_hr, al_min, al_sec})),
        .match  (al_match)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[FLAG_PF] = per_evt;
        set_vec[FLAG_AF] = upd_end && al_match;
        set_vec[FLAG_UF] = upd_end;
        en_vec           = '0;
        en_vec[FLAG_PF]  = per_en;
        en_vec[FLAG_AF]  = alm_en;
        en_vec[FLAG_UF]  = upd_en;
    end

    rtc_flag_ctrl u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .en_vec  (en_vec),
        .rd_stat (rd_stat),
        .stat_q  (stat_q),
        .irq_n   (irq_n)
    );

endmodule

// File: tb/rtc_event_irq_test.sv
module rtc_event_irq_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [14:0] div_q;
    logic [3:0]  rate_sel;
    logic        per_en, alm_en, upd_en, sqw_en, upd_end, rd_stat;
    logic [7:0]  tm_sec, tm_min, tm_hr, al_sec, al_min, al_hr;
    logic [7:0]  stat_q;
    logic        irq_n, sqw;

    int n_cmp = 0;
    int n_bad = 0;

    // model state
    logic [2:0] m_flags = '0;   // {pf, af, uf}
    logic [7:0] m_stat  = '0;
    logic       m_sqw   = 1'b0;
    logic       m_irq_n = 1'b1;
    logic       m_rd_prev = 1'b0, m_tap_prev = 1'b0, m_valid = 1'b0;
    logic [3:0] m_rate_prev = '0;

    always #10 clk = ~clk;

    rtc_event_irq uut (
        .clk(clk), .rst_n(rst_n), .div_q(div_q), .rate_sel(rate_sel),
        .per_en(per_en), .alm_en(alm_en), .upd_en(upd_en), .sqw_en(sqw_en),
        .upd_end(upd_end), .tm_sec(tm_sec), .tm_min(tm_min), .tm_hr(tm_hr),
        .al_sec(al_sec), .al_min(al_min), .al_hr(al_hr), .rd_stat(rd_stat),
        .stat_q(stat_q), .irq_n(irq_n), .sqw(sqw)
    );

    function automatic logic f_tap(input logic [14:0] d, input logic [3:0] r);
        return (r == 4'd0) ? 1'b0 : d[r-1];
    endfunction

    function automatic logic f_fmatch(input logic [7:0] a, input logic [7:0] t);
        return (a[7:6] == 2'b11) || (a == t);
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // advance the model by one edge using the inputs now applied
    task automatic model_edge;
        logic       tap, pev, fire, live, amatch;
        logic [2:0] en;
        tap    = f_tap(div_q, rate_sel);
        pev    = m_valid && (rate_sel == m_rate_prev) && !m_tap_prev && tap && (rate_sel != 0);
        fire   = rd_stat && !m_rd_prev;
        en     = {per_en, alm_en, upd_en};
        live   = |(m_flags & en);
        amatch = f_fmatch(al_sec, tm_sec) && f_fmatch(al_min, tm_min) && f_fmatch(al_hr, tm_hr);
        if (fire) m_stat = {live, m_flags, 4'b0000};
        m_flags     = (fire ? 3'b000 : m_flags) | {pev, upd_end && amatch, upd_end};
        m_sqw       = sqw_en && (rate_sel != 0) && tap;
        m_irq_n     = !(|(m_flags & en));
        m_tap_prev  = tap;
        m_valid     = (rate_sel != 0);
        m_rate_prev = rate_sel;
        m_rd_prev   = rd_stat;
    endtask

    task automatic step;
        model_edge();
        @(posedge clk);
        @(negedge clk);
        chk("R6 irq_n", {7'd0, irq_n}, {7'd0, m_irq_n});
        chk("R5 sqw", {7'd0, sqw}, {7'd0, m_sqw});
        chk("R7 stat_q", stat_q, m_stat);
    endtask

    task automatic rd_pulse;
        rd_stat = 1'b1; step();
        rd_stat = 1'b0; step();
    endtask

    task automatic upd_pulse;
        upd_end = 1'b1; step();
        upd_end = 1'b0; step();
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; div_q = '0; rate_sel = '0;
        per_en = 0; alm_en = 0; upd_en = 0; sqw_en = 0; upd_end = 0; rd_stat = 0;
        tm_sec = 8'd1; tm_min = 8'd1; tm_hr = 8'd1;
        al_sec = 8'd0; al_min = 8'd0; al_hr = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq_n reset", {7'd0, irq_n}, 8'd1);
        chk("R1 sqw reset", {7'd0, sqw}, 8'd0);
        chk("R1 stat reset", stat_q, 8'h00);

        // R2: masked update still flags
        upd_pulse();
        chk("R2 masked irq_n", {7'd0, irq_n}, 8'd1);
        rd_pulse();
        chk("R2 uf captured", stat_q, 8'h10);
        rd_pulse();
        chk("R7 flags cleared", stat_q, 8'h00);

        // R3: seconds don't-care, minutes and hours equal
        al_sec = 8'hC5; al_min = 8'd1; al_hr = 8'd1; alm_en = 1'b1;
        upd_pulse();
        chk("R3 alarm irq_n", {7'd0, irq_n}, 8'd0);
        rd_pulse();
        chk("R3 alarm byte", stat_q, 8'hB0);
        chk("R7 irq released", {7'd0, irq_n}, 8'd1);
        al_min = 8'd2;
        upd_pulse();
        rd_pulse();
        chk("R3 mismatch no af", stat_q, 8'h10);

        // R4: edge on bit 2 with rate 3
        rate_sel = 4'd3; div_q = 15'd0; step(); step();
        div_q = 15'd4; step();
        chk("R4 masked periodic", {7'd0, irq_n}, 8'd1);
        rd_pulse();
        chk("R4 pf captured", stat_q, 8'h40);
        div_q = 15'd0; step();
        rate_sel = 4'd4; div_q = 15'd8; step(); step();
        rd_pulse();
        chk("R4 rate change no event", stat_q, 8'h00);

        // R5: square wave gating
        sqw_en = 1'b1; rate_sel = 4'd2; div_q = 15'd2; step();
        chk("R5 sqw high", {7'd0, sqw}, 8'd1);
        div_q = 15'd0; step();
        chk("R5 sqw low", {7'd0, sqw}, 8'd0);
        div_q = 15'd2; sqw_en = 1'b0; step();
        chk("R5 sqw disabled", {7'd0, sqw}, 8'd0);
        sqw_en = 1'b1; rate_sel = 4'd0; step();
        chk("R5 rate zero", {7'd0, sqw}, 8'd0);
        rd_pulse();

        // R8: event coincident with read
        per_en = 1'b1; upd_en = 1'b1; rate_sel = 4'd3; div_q = 15'd0; step();
        div_q = 15'd4; step();
        chk("R6 periodic irq", {7'd0, irq_n}, 8'd0);
        rd_stat = 1'b1; upd_end = 1'b1; step();
        chk("R8 old flags captured", stat_q, 8'hC0);
        rd_stat = 1'b0; upd_end = 1'b0; step();
        chk("R8 new flag kept", {7'd0, irq_n}, 8'd0);
        rd_pulse();
        chk("R8 uf read later", stat_q, 8'h90);

        // R9: held strobe does not re-capture
        rd_pulse();
        rd_stat = 1'b1; step();
        upd_end = 1'b1; step();
        upd_end = 1'b0; step();
        chk("R9 stat held", stat_q, 8'h00);
        chk("R9 flag during hold", {7'd0, irq_n}, 8'd0);
        rd_stat = 1'b0; step();
        rd_pulse();
        chk("R7 second read", stat_q, 8'h90);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            div_q = div_q + 15'd1;
            if ($urandom % 24 == 0) rate_sel = 4'($urandom % 16);
            if ($urandom % 32 == 0) {per_en, alm_en, upd_en, sqw_en} = 4'($urandom);
            upd_end = ($urandom % 8 == 0);
            tm_sec = 8'($urandom % 3); tm_min = 8'($urandom % 3); tm_hr = 8'($urandom % 3);
            al_sec = ($urandom % 3 == 0) ? 8'hC0 | 8'($urandom % 64) : 8'($urandom % 3);
            al_min = ($urandom % 3 == 0) ? 8'hC0 : 8'($urandom % 3);
            al_hr  = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom % 3);
            rd_stat = ($urandom % 6 == 0) || (rd_stat && ($urandom % 2 == 0));
            step();
        end

        summary();
        $finish;
    end

endmodule